// File: doc/BRIEF.md
# Column Burst Engine with Clock-Enable Freeze

This block is the column-access core of a single-data-rate synchronous DRAM model. Once a READ or WRITE is accepted, it steps through a fixed-length burst of columns in a small internal word array. It also honours a clock-enable input. When that input is sampled low while a burst is running, the internal clock strobe is withheld on the following edge. The burst then freezes in place, even though the external clock keeps running.

The block has a single clock domain and takes a decoded two-bit command. While a burst runs, each internal edge that is allowed to fire moves the burst forward by one column. Column addresses wrap inside the aligned group of `BURST_LEN` words. Read data leaves through a registered output with its own enable. Write data is taken from the input bus on every edge of a write burst that is not frozen. Reading a column back is the only way to see what the array holds.

Top module: `sdram_burst_suspend`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, the burst ends and `rdata_oe` goes to 0 on that edge. The clock-enable history resets to "enabled".
- R2: Command codes are 00 NOP, 01 READ, 10 WRITE and 11 treated as NOP. A READ at column n drives `rdata_oe` high on the next internal edge. On that edge and the three internal edges after it, `rdata` carries the words at n, n+1, n+2 and n+3. The low two column bits wrap modulo 4, and the upper bits stay the same.
- R3: A WRITE at column n stores `wdata` into column n on the command edge. On each of the next three internal edges it stores `wdata` into the next wrapped column.
- R4: When `cke` is sampled low on a rising edge while a burst is active, the next rising edge is suspended. On that edge the column position does not advance, and `rdata` and `rdata_oe` keep their values.
- R5: Write data present on a suspended edge is not stored.
- R6: When no burst is active, a low `cke` has no effect, and a READ or WRITE on that edge is accepted.
- R7: A high `cke` sampled on an edge lets the burst resume on the following edge.
- R8: `rdata_oe` falls on the first internal edge after the fourth read word and stays low until another read delivers data.
- R9: A READ or WRITE presented while a burst is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable, sampled each rising edge |
| cmd | input | 2 | Decoded command: 00 NOP, 01 READ, 10 WRITE, 11 NOP |
| col | input | COL_W (4) | Starting column for READ/WRITE |
| wdata | input | DATA_W (8) | Write data word |
| rdata | output | DATA_W (8) | Registered read data |
| rdata_oe | output | 1 | High while read data is being driven |

## Verification
The bench starts bursts at columns that are not aligned, so the wrap inside the group is tested. A design that carries into the upper column bits would return words from the neighbouring group. It drops `cke` exactly one edge after a READ or WRITE and in the middle of a burst. A design with the wrong latency would freeze one edge early or late, and a design that ignores the freeze would skip a word or store the suspended write word. It also drops `cke` while the engine is idle and sends commands during a burst. Either mistake would stall an idle engine or start a new burst on top of the running one, and the result shows up when the array is read back. Constrained-random traffic with a fixed seed is compared cycle by cycle against a reference model in the bench.

// File: rtl/sdsus_pkg.sv
package sdsus_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_RSVD  = 2'b11
   } sdsus_cmd_e;
endpackage

// File: rtl/sdsus_cke_gate.sv
module sdsus_cke_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic busy,
   output logic tick
);
   logic cke_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cke_q <= 1'b1;
      else        cke_q <= cke;
   end

   // a low sample only freezes an edge while a burst is running
   assign tick = !(busy && !cke_q);
endmodule

// File: rtl/sdsus_burst_ctrl.sv
module sdsus_burst_ctrl
   import sdsus_pkg::*;
#(
   parameter int COL_W     = 4,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  sdsus_cmd_e       cmd,
   input  logic [COL_W-1:0] col,
   output logic             active,
   output logic             wr_en,
   output logic [COL_W-1:0] wr_addr,
   output logic             rd_en,
   output logic [COL_W-1:0] rd_addr,
   output logic             oe
);
   localparam int BL_W = $clog2(BURST_LEN);
   localparam logic [BL_W-1:0] LAST = BL_W'(BURST_LEN - 1);

   logic             is_wr;
   logic [BL_W-1:0]  cnt;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] cur_col;
   logic             accept;
   logic             new_wr;

   generate
      if (BL_W < COL_W) begin : g_wrap_part
         logic [BL_W-1:0] low_sum;
         assign low_sum = base[BL_W-1:0] + cnt;
         assign cur_col = {base[COL_W-1:BL_W], low_sum};
      end else begin : g_wrap_full
         assign cur_col = base + COL_W'(cnt);
      end
   endgenerate

   assign accept  = tick && !active && (cmd == CMD_READ || cmd == CMD_WRITE);
   assign new_wr  = (cmd == CMD_WRITE);
   assign wr_en   = (accept && new_wr) || (tick && active && is_wr);
   assign wr_addr = accept ? col : cur_col;
   assign rd_en   = tick && active && !is_wr;
   assign rd_addr = cur_col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         is_wr  <= 1'b0;
         cnt    <= '0;
         base   <= '0;
         oe     <= 1'b0;
      end else if (tick) begin
         oe <= active && !is_wr;
         if (accept) begin
            active <= 1'b1;
            is_wr  <= new_wr;
            base   <= col;
            cnt    <= new_wr ? BL_W'(1) : '0;
         end else if (active) begin
            cnt <= cnt + BL_W'(1);
            if (cnt == LAST) active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdsus_col_store.sv
module sdsus_col_store #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [COL_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [COL_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << COL_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[wr_addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= words[rd_addr];
   end
endmodule

// File: rtl/sdram_burst_suspend.sv
module sdram_burst_suspend
   import sdsus_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int COL_W     = 4,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic [1:0]        cmd,
   input  logic [COL_W-1:0]  col,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_len
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if ((1 << COL_W) < BURST_LEN) begin : g_bad_col
         $error("COL_W too narrow for BURST_LEN");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic             tick;
   logic             burst_on;
   logic             wr_en;
   logic             rd_en;
   logic [COL_W-1:0] wr_addr;
   logic [COL_W-1:0] rd_addr;
   sdsus_cmd_e       cmd_e;

   assign cmd_e = sdsus_cmd_e'(cmd);

   sdsus_cke_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .busy  (burst_on),
      .tick  (tick)
   );

   sdsus_burst_ctrl #(
      .COL_W     (COL_W),
      .BURST_LEN (BURST_LEN)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cmd     (cmd_e),
      .col     (col),
      .active  (burst_on),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .oe      (rdata_oe)
   );

   sdsus_col_store #(
      .DATA_W (DATA_W),
      .COL_W  (COL_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wdata   (wdata),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rdata   (rdata)
   );
endmodule

// File: rtl/sdsus_chk.sv
module sdsus_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic [1:0]        cmd,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_oe,
   input logic              burst_on
);
   logic cke_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) cke_seen <= 1'b1;
      else        cke_seen <= cke;
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (!rdata_oe && !burst_on));

   // R4
   frozen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_on && !cke_seen) |=>
         ($stable(rdata) && $stable(rdata_oe) && $stable(burst_on)));

   // R6
   idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_on && (cmd == 2'b01 || cmd == 2'b10)) |=> burst_on);

   // R8
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_on && rdata_oe) |=> !rdata_oe);
endmodule

bind sdram_burst_suspend sdsus_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cke      (cke),
   .cmd      (cmd),
   .rdata    (rdata),
   .rdata_oe (rdata_oe),
   .burst_on (burst_on)
);

// File: tb/sdram_burst_suspend_test.sv
module sdram_burst_suspend_test;
   localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic [1:0] cmd = NOP;
   logic [3:0] col = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rdata_oe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   logic       m_cke_q = 1'b1;
   logic       m_act = 1'b0;
   logic       m_wr = 1'b0;
   logic [1:0] m_cnt = '0;
   logic [3:0] m_base = '0;
   logic       m_oe = 1'b0;
   logic [7:0] m_rdata = '0;
   logic [7:0] m_mem [16];

   sdram_burst_suspend uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .col(col),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   always #2 clk = ~clk;

   function automatic logic [3:0] wrap_col(logic [3:0] b, logic [1:0] k);
      return {b[3:2], 2'(b[1:0] + k)};
   endfunction

   always @(posedge clk) begin
      logic tk;
      logic [3:0] cc;
      if (!rst_n) begin
         m_act = 0; m_wr = 0; m_cnt = 0; m_base = 0;
         m_oe = 0; m_rdata = 0; m_cke_q = 1;
      end else begin
         tk = !(m_act && !m_cke_q);
         if (tk) begin
            cc = wrap_col(m_base, m_cnt);
            if (!m_act && (cmd == RD || cmd == WR)) begin
               if (cmd == WR) m_mem[col] = wdata;
               m_act = 1; m_wr = (cmd == WR); m_base = col;
               m_cnt = (cmd == WR) ? 2'd1 : 2'd0;
               m_oe = 0;
            end else if (m_act) begin
               if (m_wr) m_mem[cc] = wdata;
               else m_rdata = m_mem[cc];
               m_oe = !m_wr;
               if (m_cnt == 2'd3) m_act = 0;
               m_cnt = m_cnt + 2'd1;
            end else begin
               m_oe = 0;
            end
         end
         m_cke_q = cke;
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
         summary();
         $finish;
      end
   end

   task automatic compare();
      checks++;
      if (rdata_oe !== m_oe) begin
         errors++;
         $display("FAIL %s: rdata_oe actual %b expected %b at cycle %0d", tag, rdata_oe, m_oe, cycles);
      end
      if (m_oe) begin
         checks++;
         if (rdata !== m_rdata) begin
            errors++;
            $display("FAIL %s: rdata actual %h expected %h at cycle %0d", tag, rdata, m_rdata, cycles);
         end
      end
   endtask

   task automatic step(input logic c, input logic [1:0] cm, input logic [3:0] cl, input logic [7:0] wd);
      @(negedge clk);
      compare();
      cke = c; cmd = cm; col = cl; wdata = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b1, NOP, 4'h0, 8'h00);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: outputs idle during and right after reset
      checks++;
      if (rdata_oe !== 1'b0) begin
         errors++;
         $display("FAIL R1: rdata_oe actual %b expected 0", rdata_oe);
      end
      rst_n = 1'b1;
      idle(2);

      // R3: unaligned write wraps, then fill remaining groups
      tag = "R3";
      step(1, WR, 4'd2, 8'hA2);
      step(1, NOP, 4'd0, 8'hA3);
      step(1, NOP, 4'd0, 8'hA0);
      step(1, NOP, 4'd0, 8'hA1);
      for (int g = 1; g < 4; g++) begin
         step(1, WR, 4'(g * 4), 8'(8'h10 * g));
         for (int k = 1; k < 4; k++) step(1, NOP, 4'd0, 8'(8'h10 * g + k));
      end
      idle(2);

      // R2: read from an unaligned column with wrap, then R8 release
      tag = "R2";
      step(1, RD, 4'd1, 8'h00);
      idle(4);
      tag = "R8";
      idle(3);

      // R4 / R7: freeze mid read burst, then resume
      tag = "R4";
      step(1, RD, 4'd5, 8'h00);
      step(1, NOP, 4'd0, 8'h00);
      step(0, NOP, 4'd0, 8'h00);
      step(0, RD, 4'd9, 8'h00);
      tag = "R7";
      step(1, NOP, 4'd0, 8'h00);
      idle(6);

      // R5: write with a suspended edge carrying junk data
      tag = "R5";
      step(1, WR, 4'd8, 8'hC0);
      step(0, NOP, 4'd0, 8'hC1);
      step(1, NOP, 4'd0, 8'hEE);
      step(1, NOP, 4'd0, 8'hC1);
      step(1, NOP, 4'd0, 8'hC2);
      step(1, NOP, 4'd0, 8'hC3);
      idle(2);
      step(1, RD, 4'd8, 8'h00);
      idle(6);

      // R6: low cke while idle does not block a command
      tag = "R6";
      step(0, NOP, 4'd0, 8'h00);
      step(0, RD, 4'd14, 8'h00);
      step(1, NOP, 4'd0, 8'h00);
      idle(7);

      // R9: commands during a burst are ignored
      tag = "R9";
      step(1, RD, 4'd12, 8'h00);
      step(1, WR, 4'd12, 8'h55);
      step(1, RD, 4'd0, 8'h55);
      step(1, WR, 4'd13, 8'h66);
      idle(3);
      step(1, RD, 4'd12, 8'h00);
      idle(6);

      // constrained random traffic
      tag = "R4";
      for (int i = 0; i < 600; i++) begin
         int r;
         logic [1:0] cm;
         r = int'($urandom % 10);
         cm = (r == 0) ? RD : (r == 1) ? WR : (r == 2) ? RSV : NOP;
         step(($urandom % 4) != 0, cm, 4'($urandom), 8'($urandom));
      end
      idle(8);

      done = 1;
      summary();
      $finish;
   end
endmodule